// File: doc/BRIEF.md
# Corrected Error Threshold Monitor

This block sits beside a memory's error-correction logic and tallies the errors that logic has already corrected. The correction logic sends a one-cycle pulse for each corrected error. One pulse input serves processor accesses and another serves DMA accesses. Both inputs feed one shared counter, so two pulses in the same cycle add two.

When the count reaches a programmed limit, the block sets a sticky status bit. It can also raise a level interrupt when that interrupt is enabled. Software can force the status bit to test its handler, and clears it by writing a one to a separate clear register.

Software reaches six 32-bit word registers over a simple register bus. Writes take effect on the clock edge of a single-cycle strobe. A read returns its data one cycle after the read strobe.

Register offsets used throughout: 0x00 error count, 0x04 limit, 0x08 status, 0x0C force, 0x10 clear, 0x14 interrupt enable.

Top module: `ce_thresh_mon`

## Requirements
- R1: After reset (asynchronous, active low) the count, limit, status bit, interrupt enable and read data are all 0, and `irq_o` is low.
- R2: Each pulse on `cpu_err_i` or `dma_err_i` adds one to the count, and pulses on both inputs in one cycle add two. The count reads at offset 0x00 in bits 15:0, and bits 31:16 read 0.
- R3: The count stops at 0xFFFF and further pulses leave it there. Any write to offset 0x00 clears it whatever the data. A pulse that arrives in the same cycle as that write is counted from zero.
- R4: The limit at offset 0x04 holds bits 15:0 of the written data. On read, bits 31:16 return 0.
- R5: Status bit 0 at offset 0x08 sets in the cycle in which a pulse moves the count to a value equal to the limit. It does not set when a double pulse steps the count over the limit, and it does not set when the count does not move. A limit of 0 with a count of 0 therefore never sets it.
- R6: Once set, the status bit stays set until a write with bit 0 = 1 to offset 0x10. A write there with bit 0 = 0 has no effect.
- R7: A write with bit 0 = 1 to offset 0x0C sets the status bit. Reads of offset 0x0C, offset 0x10 and status bits 31:1 always return 0.
- R8: If the status bit is set and cleared in the same cycle, it ends up set.
- R9: `irq_o` is high exactly while the status bit and interrupt-enable bit 0 at offset 0x14 are both 1. This holds whether the bit was set by a match or by a force.
- R10: `bus_rdata_o` takes the addressed register's value on the clock edge of a `bus_rd_i` cycle and keeps it until the next read. Unmapped or misaligned offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_err_i | input | 1 | One-cycle pulse per corrected error on a processor access |
| dma_err_i | input | 1 | One-cycle pulse per corrected error on a DMA access |
| bus_wr_i | input | 1 | Write strobe, one cycle |
| bus_rd_i | input | 1 | Read strobe, one cycle |
| bus_addr_i | input | 5 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt, status AND enable |

## Verification
The assertions assume that the reset is applied before the first access. They also assume that the bus never raises read and write in the same cycle, since the checks on read data and status ignore a write hidden behind a read. The bench drives every access alone, one strobe per cycle. It changes error pulses and strobes only on the falling edge, so every pulse lasts exactly one clock cycle.

// File: rtl/cetm_pkg.sv
package cetm_pkg;

   localparam int unsigned OFS_COUNT  = 'h00;
   localparam int unsigned OFS_LIMIT  = 'h04;
   localparam int unsigned OFS_STATUS = 'h08;
   localparam int unsigned OFS_FORCE  = 'h0C;
   localparam int unsigned OFS_CLEAR  = 'h10;
   localparam int unsigned OFS_IRQEN  = 'h14;

   typedef enum logic [2:0] {
      SEL_COUNT,
      SEL_LIMIT,
      SEL_STATUS,
      SEL_FORCE,
      SEL_CLEAR,
      SEL_IRQEN,
      SEL_NONE
   } reg_sel_e;

   function automatic reg_sel_e sel_of(input logic [7:0] ofs);
      reg_sel_e s;
      case (ofs)
         8'(OFS_COUNT):  s = SEL_COUNT;
         8'(OFS_LIMIT):  s = SEL_LIMIT;
         8'(OFS_STATUS): s = SEL_STATUS;
         8'(OFS_FORCE):  s = SEL_FORCE;
         8'(OFS_CLEAR):  s = SEL_CLEAR;
         8'(OFS_IRQEN):  s = SEL_IRQEN;
         default:        s = SEL_NONE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/cetm_err_counter.sv
module cetm_err_counter #(
   parameter int unsigned CNT_W    = 16,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_hit_i,
   input  logic             dma_hit_i,
   input  logic             clr_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             match_o
);

   localparam int unsigned SUM_W = CNT_W + 1;

   logic [1:0]       inc;
   logic [CNT_W-1:0] base;
   logic [SUM_W-1:0] sum;
   logic [CNT_W-1:0] cnt_d;
   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      inc  = {1'b0, cpu_hit_i} + {1'b0, dma_hit_i};
      base = clr_i ? '0 : cnt_q;
      sum  = {1'b0, base} + SUM_W'(inc);
   end

   generate
      if (SATURATE) begin : g_sat
         always_comb cnt_d = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
      end else begin : g_wrap
         always_comb cnt_d = sum[CNT_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   // a match needs a pulse that actually moves the count onto the limit
   always_comb match_o = (inc != 2'd0) && (cnt_d != cnt_q) && (cnt_d == limit_i);

   assign cnt_o = cnt_q;

endmodule

// File: rtl/cetm_flag_ctl.sv
module cetm_flag_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic match_i,
   input  logic force_i,
   input  logic clear_i,
   input  logic irq_en_i,
   output logic flag_o,
   output logic irq_o
);

   logic flag_q;
   logic set_ev;

   always_comb set_ev = match_i | force_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (set_ev)  flag_q <= 1'b1;
      else if (clear_i) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;
   assign irq_o  = flag_q & irq_en_i;

endmodule

// File: rtl/cetm_regbank.sv
module cetm_regbank
   import cetm_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              flag_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [CNT_W-1:0]  limit_o,
   output logic              irq_en_o,
   output logic              cnt_clr_o,
   output logic              force_o,
   output logic              clear_o
);

   logic             hi_zero;
   logic [7:0]       lo_ofs;
   reg_sel_e         sel;
   logic [CNT_W-1:0] limit_q;
   logic             irq_en_q;
   logic [DATA_W-1:0] rd_word;
   logic [DATA_W-1:0] rdata_q;
   logic             unused_wdata;

   generate
      if (ADDR_W > 8) begin : g_wide_addr
         always_comb hi_zero = ~|addr_i[ADDR_W-1:8];
      end else begin : g_narrow_addr
         always_comb hi_zero = 1'b1;
      end
   endgenerate

   always_comb begin
      lo_ofs = 8'(addr_i);
      sel    = hi_zero ? sel_of(lo_ofs) : SEL_NONE;
   end

   assign unused_wdata = ^wdata_i;

   always_comb begin
      cnt_clr_o = wr_i && (sel == SEL_COUNT);
      force_o   = wr_i && (sel == SEL_FORCE) && wdata_i[0];
      clear_o   = wr_i && (sel == SEL_CLEAR) && wdata_i[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         limit_q  <= '0;
         irq_en_q <= 1'b0;
      end else if (wr_i) begin
         if (sel == SEL_LIMIT) limit_q  <= wdata_i[CNT_W-1:0];
         if (sel == SEL_IRQEN) irq_en_q <= wdata_i[0];
      end
   end

   always_comb begin
      case (sel)
         SEL_COUNT:  rd_word = DATA_W'(cnt_i);
         SEL_LIMIT:  rd_word = DATA_W'(limit_q);
         SEL_STATUS: rd_word = DATA_W'(flag_i);
         SEL_IRQEN:  rd_word = DATA_W'(irq_en_q);
         default:    rd_word = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rdata_q <= '0;
      else if (rd_i) rdata_q <= rd_word;
   end

   assign rdata_o  = rdata_q;
   assign limit_o  = limit_q;
   assign irq_en_o = irq_en_q;

endmodule

// File: rtl/ce_thresh_mon.sv
module ce_thresh_mon #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned CNT_W    = 16,
   parameter bit          SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_err_i,
   input  logic              dma_err_i,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              irq_o
);

   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
         $error("ce_thresh_mon: CNT_W must lie in 2..DATA_W");
      end
      if (ADDR_W < 5) begin : g_bad_addr_w
         $error("ce_thresh_mon: ADDR_W must reach offset 0x14");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit_q;
   logic             irq_en_q;
   logic             flag_q;
   logic             match;
   logic             cnt_clr;
   logic             force_set;
   logic             flag_clr;

   cetm_regbank #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (bus_wr_i),
      .rd_i      (bus_rd_i),
      .addr_i    (bus_addr_i),
      .wdata_i   (bus_wdata_i),
      .cnt_i     (cnt_q),
      .flag_i    (flag_q),
      .rdata_o   (bus_rdata_o),
      .limit_o   (limit_q),
      .irq_en_o  (irq_en_q),
      .cnt_clr_o (cnt_clr),
      .force_o   (force_set),
      .clear_o   (flag_clr)
   );

   cetm_err_counter #(
      .CNT_W    (CNT_W),
      .SATURATE (SATURATE)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_hit_i (cpu_err_i),
      .dma_hit_i (dma_err_i),
      .clr_i     (cnt_clr),
      .limit_i   (limit_q),
      .cnt_o     (cnt_q),
      .match_o   (match)
   );

   cetm_flag_ctl u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .match_i  (match),
      .force_i  (force_set),
      .clear_i  (flag_clr),
      .irq_en_i (irq_en_q),
      .flag_o   (flag_q),
      .irq_o    (irq_o)
   );

endmodule

// File: rtl/cetm_chk.sv
module cetm_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_err_i,
   input logic              dma_err_i,
   input logic              bus_wr_i,
   input logic              bus_rd_i,
   input logic [ADDR_W-1:0] bus_addr_i,
   input logic [DATA_W-1:0] bus_wdata_i,
   input logic [DATA_W-1:0] bus_rdata_o,
   input logic              irq_o,
   input logic [CNT_W-1:0]  cnt,
   input logic              flag,
   input logic              irq_en
);

   logic wr_cnt, wr_force1, wr_clear1, rd_force;

   always_comb begin
      wr_cnt    = bus_wr_i && (bus_addr_i == ADDR_W'(12'h000));
      wr_force1 = bus_wr_i && (bus_addr_i == ADDR_W'(12'h00C)) && bus_wdata_i[0];
      wr_clear1 = bus_wr_i && (bus_addr_i == ADDR_W'(12'h010)) && bus_wdata_i[0];
      rd_force  = bus_rd_i && (bus_addr_i == ADDR_W'(12'h00C));
   end

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_cnt |=> ((cnt - $past(cnt)) <= CNT_W'(2))) else $error("count step"); // R2

   AST_CNT_HOLD_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      (&cnt) && !wr_cnt |=> (&cnt)) else $error("saturation lost"); // R3

   AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      !flag && !wr_force1 && !cpu_err_i && !dma_err_i |=> !flag) else $error("flag set with no event"); // R5

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      flag && !wr_clear1 |=> flag) else $error("flag dropped"); // R6

   AST_FORCE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_force1 |=> flag) else $error("force ignored"); // R7

   AST_FORCE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_force |=> (bus_rdata_o == '0)) else $error("force readback"); // R7

   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (irq_en && flag)) else $error("irq without cause"); // R9

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_i |=> $stable(bus_rdata_o)) else $error("rdata moved"); // R10

endmodule

bind ce_thresh_mon cetm_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cpu_err_i   (cpu_err_i),
   .dma_err_i   (dma_err_i),
   .bus_wr_i    (bus_wr_i),
   .bus_rd_i    (bus_rd_i),
   .bus_addr_i  (bus_addr_i),
   .bus_wdata_i (bus_wdata_i),
   .bus_rdata_o (bus_rdata_o),
   .irq_o       (irq_o),
   .cnt         (cnt_q),
   .flag        (flag_q),
   .irq_en      (irq_en_q)
);

// File: tb/tb_ce_thresh_mon.sv
module tb_ce_thresh_mon;

   localparam int CLK_PERIOD = 10;

   localparam logic [1:0] K_W = 2'd0;
   localparam logic [1:0] K_R = 2'd1;
   localparam logic [1:0] K_P = 2'd2;

   typedef struct packed {
      logic [1:0]  kind;
      logic [4:0]  addr;
      logic [31:0] data;
      logic        cpu;
      logic        dma;
      logic [31:0] exp;
      logic        irq;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 32;
   localparam vec_t VEC [NV] = '{
      '{K_R, 5'h00, 32'h0,        1'b0, 1'b0, 32'h0,          1'b0, 4'd1},  // R1 count
      '{K_R, 5'h04, 32'h0,        1'b0, 1'b0, 32'h0,          1'b0, 4'd1},  // R1 limit
      '{K_R, 5'h08, 32'h0,        1'b0, 1'b0, 32'h0,          1'b0, 4'd1},  // R1 status
      '{K_W, 5'h04, 32'hABCD0005, 1'b0, 1'b0, 32'h0,          1'b0, 4'd4},  // R4
      '{K_R, 5'h04, 32'h0,        1'b0, 1'b0, 32'h00000005,   1'b0, 4'd4},  // R4 upper bits zero
      '{K_W, 5'h14, 32'h1,        1'b0, 1'b0, 32'h0,          1'b0, 4'd9},  // R9 enable
      '{K_P, 5'h00, 32'h0,        1'b1, 1'b0, 32'h0,          1'b0, 4'd2},  // R2 count 1
      '{K_P, 5'h00, 32'h0,        1'b1, 1'b1, 32'h0,          1'b0, 4'd2},  // R2 count 3
      '{K_R, 5'h00, 32'h0,        1'b0, 1'b0, 32'h3,          1'b0, 4'd2},  // R2
      '{K_R, 5'h08, 32'h0,        1'b0, 1'b0, 32'h0,          1'b0, 4'd5},  // R5 below limit
      '{K_P, 5'h00, 32'h0,        1'b0, 1'b1, 32'h0,          1'b0, 4'd2},  // R2 count 4
      '{K_P, 5'h00, 32'h0,        1'b1, 1'b0, 32'h0,          1'b1, 4'd5},  // R5 count 5 hits
      '{K_R, 5'h08, 32'h0,        1'b0, 1'b0, 32'h1,          1'b1, 4'd5},  // R5
      '{K_P, 5'h00, 32'h0,        1'b1, 1'b0, 32'h0,          1'b1, 4'd6},  // R6 past limit
      '{K_W, 5'h10, 32'hFFFFFFFE, 1'b0, 1'b0, 32'h0,          1'b1, 4'd6},  // R6 bit0 zero
      '{K_R, 5'h08, 32'h0,        1'b0, 1'b0, 32'h1,          1'b1, 4'd6},  // R6
      '{K_W, 5'h10, 32'h1,        1'b0, 1'b0, 32'h0,          1'b0, 4'd6},  // R6 clear
      '{K_R, 5'h08, 32'h0,        1'b0, 1'b0, 32'h0,          1'b0, 4'd6},  // R6
      '{K_W, 5'h14, 32'h0,        1'b0, 1'b0, 32'h0,          1'b0, 4'd9},  // R9 disable
      '{K_W, 5'h0C, 32'hFFFFFFFF, 1'b0, 1'b0, 32'h0,          1'b0, 4'd7},  // R7 force, irq off
      '{K_R, 5'h0C, 32'h0,        1'b0, 1'b0, 32'h0,          1'b0, 4'd7},  // R7 reads zero
      '{K_R, 5'h08, 32'h0,        1'b0, 1'b0, 32'h1,          1'b0, 4'd7},  // R7 forced flag
      '{K_W, 5'h14, 32'h1,        1'b0, 1'b0, 32'h0,          1'b1, 4'd9},  // R9 forced raises irq
      '{K_W, 5'h10, 32'h1,        1'b0, 1'b0, 32'h0,          1'b0, 4'd9},  // R9 drop
      '{K_W, 5'h00, 32'h00001234, 1'b0, 1'b0, 32'h0,          1'b0, 4'd3},  // R3 clear count
      '{K_R, 5'h00, 32'h0,        1'b0, 1'b0, 32'h0,          1'b0, 4'd3},  // R3
      '{K_W, 5'h04, 32'h1,        1'b0, 1'b0, 32'h0,          1'b0, 4'd4},  // R4 limit 1
      '{K_P, 5'h00, 32'h0,        1'b1, 1'b1, 32'h0,          1'b0, 4'd5},  // R5 step over
      '{K_R, 5'h08, 32'h0,        1'b0, 1'b0, 32'h0,          1'b0, 4'd5},  // R5
      '{K_R, 5'h18, 32'h0,        1'b0, 1'b0, 32'h0,          1'b0, 4'd10}, // R10 unmapped
      '{K_R, 5'h10, 32'h0,        1'b0, 1'b0, 32'h0,          1'b0, 4'd7},  // R7 clear reg reads zero
      '{K_R, 5'h14, 32'h0,        1'b0, 1'b0, 32'h1,          1'b0, 4'd9}   // R9 enable readback
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_err_i = 1'b0;
   logic        dma_err_i = 1'b0;
   logic        bus_wr_i = 1'b0;
   logic        bus_rd_i = 1'b0;
   logic [4:0]  bus_addr_i = '0;
   logic [31:0] bus_wdata_i = '0;
   logic [31:0] bus_rdata_o;
   logic        irq_o;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ce_thresh_mon dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .cpu_err_i   (cpu_err_i),
      .dma_err_i   (dma_err_i),
      .bus_wr_i    (bus_wr_i),
      .bus_rd_i    (bus_rd_i),
      .bus_addr_i  (bus_addr_i),
      .bus_wdata_i (bus_wdata_i),
      .bus_rdata_o (bus_rdata_o),
      .irq_o       (irq_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   // one bus/pulse cycle: drive at falling edge, commit at rising edge, release at falling edge
   task automatic cyc(input logic wr, input logic rd, input logic [4:0] a,
                      input logic [31:0] d, input logic c, input logic m);
      @(negedge clk);
      bus_wr_i = wr; bus_rd_i = rd; bus_addr_i = a; bus_wdata_i = d;
      cpu_err_i = c; dma_err_i = m;
      @(negedge clk);
      bus_wr_i = 1'b0; bus_rd_i = 1'b0; cpu_err_i = 1'b0; dma_err_i = 1'b0;
   endtask

   task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
      cyc(1'b0, 1'b1, a, '0, 1'b0, 1'b0);
      check(tag, bus_rdata_o, exp);
   endtask

   task automatic finish_run;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 rdata at reset", bus_rdata_o, 32'h0);
      check("R1 irq at reset", {31'h0, irq_o}, 32'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         cyc(VEC[i].kind == K_W, VEC[i].kind == K_R, VEC[i].addr, VEC[i].data,
             VEC[i].cpu, VEC[i].dma);
         if (VEC[i].kind == K_R)
            check($sformatf("R%0d vec%0d rdata", VEC[i].req, i), bus_rdata_o, VEC[i].exp);
         check($sformatf("R%0d vec%0d irq", VEC[i].req, i), {31'h0, irq_o}, {31'h0, VEC[i].irq});
      end

      // R5: limit 0 with count cleared to 0 never matches
      cyc(1'b1, 1'b0, 5'h04, 32'h0, 1'b0, 1'b0);
      cyc(1'b1, 1'b0, 5'h00, 32'h0, 1'b0, 1'b0);
      repeat (3) cyc(1'b0, 1'b0, 5'h00, 32'h0, 1'b0, 1'b0);
      rd_chk(5'h08, 32'h0, "R5 zero limit idle");

      // R3: pulse in the same cycle as a count clear is counted from zero
      cyc(1'b1, 1'b0, 5'h00, 32'h0, 1'b1, 1'b0);
      rd_chk(5'h00, 32'h1, "R3 clear with pulse");

      // R8: clear and match in the same cycle leave the flag set
      cyc(1'b1, 1'b0, 5'h04, 32'h3, 1'b0, 1'b0);
      cyc(1'b0, 1'b0, 5'h00, 32'h0, 1'b1, 1'b0);
      cyc(1'b1, 1'b0, 5'h10, 32'h1, 1'b1, 1'b0);
      rd_chk(5'h08, 32'h1, "R8 set beats clear");
      check("R8 irq", {31'h0, irq_o}, 32'h1);

      // R3/R5: climb to the top with double pulses
      cyc(1'b1, 1'b0, 5'h10, 32'h1, 1'b0, 1'b0);
      cyc(1'b1, 1'b0, 5'h00, 32'h0, 1'b0, 1'b0);
      cyc(1'b1, 1'b0, 5'h04, 32'h0000FFFF, 1'b0, 1'b0);
      @(negedge clk);
      cpu_err_i = 1'b1; dma_err_i = 1'b1;
      repeat (32767) @(negedge clk);
      cpu_err_i = 1'b0; dma_err_i = 1'b0;
      rd_chk(5'h00, 32'h0000FFFE, "R2 double pulse run");
      rd_chk(5'h08, 32'h0, "R5 one below top");
      cyc(1'b0, 1'b0, 5'h00, 32'h0, 1'b1, 1'b1);
      rd_chk(5'h00, 32'h0000FFFF, "R3 saturates");
      rd_chk(5'h08, 32'h1, "R5 match at top");
      cyc(1'b1, 1'b0, 5'h10, 32'h1, 1'b0, 1'b0);
      cyc(1'b0, 1'b0, 5'h00, 32'h0, 1'b1, 1'b1);
      rd_chk(5'h00, 32'h0000FFFF, "R3 held at top");
      rd_chk(5'h08, 32'h0, "R5 no match when count does not move");

      // R1: reset in mid-run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 irq in reset", {31'h0, irq_o}, 32'h0);
      rst_n = 1'b1;
      rd_chk(5'h00, 32'h0, "R1 count after reset");
      rd_chk(5'h04, 32'h0, "R1 limit after reset");
      rd_chk(5'h14, 32'h0, "R1 enable after reset");
      rd_chk(5'h08, 32'h0, "R1 status after reset");

      finish_run();
   end

endmodule